// File: doc/BRIEF.md
# Asynchronous SRAM Host Controller

This block sits between a synchronous host and a byte-wide asynchronous static memory. The host hands over one word at a time on a valid/ready request channel carrying a read/write flag, a 17-bit address and 8-bit write data. The controller turns each request into a pin sequence on the memory's active-low chip select, active-high chip select, active-low output enable and active-low write strobe. It also drives the address bus, the outgoing data with its drive enable, and samples the incoming data. Every read returns its byte on a one-cycle read-valid strobe.

Every memory timing minimum is a parameter in nanoseconds, together with the clock period. Each one is rounded up to whole cycles, so the same code meets the memory's limits at any clock rate. With the default 20 ns clock, a read holds the memory selected for 4 cycles. A write holds the strobe low for 3 cycles, then keeps the chip selected for 1 more cycle. After a read, a write may not drive the data pins until the 2-cycle output float time has passed.

An optional low-power retention interlock is also provided. While `standby_req` is high and no access is running, the memory is deselected and no request is taken. When `standby_req` falls, new requests stay locked out for a recovery time given in nanoseconds. The default recovery time is 5 ms.

Back-pressure rules: a request transfers on a clock edge where `req_valid` and `req_ready` are both high. The host must hold the request fields steady while `req_valid` is high and `req_ready` is low. `req_ready` may depend on `req_write` in the same cycle, because reads and writes face different turnaround rules. There is no back-pressure on the read-data side: the host must take `rd_data` in the cycle `rd_valid` is high.

Top module: `sram_host_ctrl`

## Requirements
- R1: After reset: the memory is deselected (`mem_cs1_n`=1, `mem_cs2`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `rd_valid`=0, and `req_ready`=1 while `standby_req` is low.
- R2: A read keeps the memory selected with `mem_oe_n` low and `mem_we_n` high for exactly RD cycles. RD is the largest of ceil(T_RC/T_CLK), ceil(T_ACC/T_CLK) and ceil(T_OE/T_CLK), which is 4 at defaults. `mem_oe_n` and `mem_we_n` are never low together.
- R3: `mem_dq_in` is sampled at the clock edge that ends the RD-cycle window. `rd_valid` is high for exactly one cycle per accepted read, RD cycles after the accepting edge. `rd_data` equals the sampled byte.
- R4: A write holds `mem_we_n` low for exactly WE cycles. WE is the largest of ceil(T_WP/T_CLK), ceil(T_AW/T_CLK) and ceil(T_DW/T_CLK), which is 3 at defaults. `mem_oe_n` stays high and `mem_dq_oe` stays high for the whole write.
- R5: A write keeps the memory selected for WE+TAIL cycles, with the address and data held steady. TAIL is max(1, ceil(T_WC/T_CLK)-WE). The byte on `mem_dq_out` is the value stored when `mem_we_n` rises.
- R6: `mem_dq_oe` never rises within HZ=ceil(T_HZ/T_CLK) cycles of `mem_oe_n` rising. A write waiting on a read starts exactly HZ cycles after that rise. A read is accepted in the first cycle after the previous access ends.
- R7: `req_ready` is low in every cycle the memory is selected. A handshake selects the memory in the next cycle.
- R8: With `standby_req` high and no access running, the memory stays deselected, `req_ready` stays low and a pending request does not start.
- R9: When `standby_req` falls, `req_ready` stays low for REC=ceil(T_REC/T_CLK) cycles after the edge that sees the fall. After that, the pending request proceeds.
- R10: A `standby_req` raised during an access lets that access finish with its full timing before the memory enters retention.
- R11: In the turnaround window after a read, `req_ready` is low for a write request but high for a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can take the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 8 | Byte returned by a read |
| standby_req | input | 1 | Request for low-power data retention |
| mem_cs1_n | output | 1 | Memory chip select, active low |
| mem_cs2 | output | 1 | Memory chip select, active high |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 17 | Memory address |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data returned by the memory |

## Verification
The memory model returns the inverted byte until the output enable has been low for RD-1 sampled cycles. A controller that samples one edge early therefore reads corrupt data, and so does one that counts the window from the wrong signal. The bench writes a walking-ones address set, then its complement, then a sweep of data patterns, and reads them all back. A design that shortened the strobe, dropped the tail cycle or let the address move before the strobe rose would show a length mismatch or a wrong readback. A read is followed at once by a write, and separately by a read. This catches a controller that drives the data bus into a still-active memory output, and one that delays reads needlessly. Retention is entered both from idle and in the middle of a write. The lockout is counted cycle by cycle, which exposes an early release, a cut-off write or a request that slips through while the chip should be asleep.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_WR    = 3'd2,
    ST_WTAIL = 3'd3,
    ST_SLEEP = 3'd4
  } ctrl_state_e;

  // Round a nanosecond minimum up to whole clock cycles, never below one.
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_down_cnt.sv
`timescale 1ns/1ps
// Loadable down counter that stops at zero.
module sram_down_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_retention_gate.sv
`timescale 1ns/1ps
// Recovery lockout after leaving retention; absent when EN is 0.
module sram_retention_gate #(
  parameter bit          EN      = 1'b1,
  parameter int unsigned REC_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned W = $clog2(REC_CYC + 1);

  generate
    if (EN) begin : g_lock
      logic idle_w;
      sram_down_cnt #(.W(W)) u_rec_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (W'(REC_CYC)),
        .zero     (idle_w)
      );
      assign busy = !idle_w;
    end else begin : g_none
      logic unused_in;
      assign unused_in = ^{clk, rst_n, start};
      assign busy      = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
// Read data register and single-cycle valid strobe.
module sram_rd_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= dq_in;
    end
  end
endmodule

// File: rtl/sram_host_ctrl.sv
`timescale 1ns/1ps
module sram_host_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned T_RC_NS       = 70,
  parameter int unsigned T_ACC_NS      = 70,
  parameter int unsigned T_OE_NS       = 40,
  parameter int unsigned T_WC_NS       = 70,
  parameter int unsigned T_WP_NS       = 55,
  parameter int unsigned T_AW_NS       = 60,
  parameter int unsigned T_DW_NS       = 30,
  parameter int unsigned T_HZ_NS       = 30,
  parameter int unsigned T_REC_NS      = 5000000,
  parameter bit          RETAIN_EN     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              standby_req,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  // Cycle budgets derived from the nanosecond minimums.
  localparam int unsigned RD_CYC   = max3(ns2cyc(T_RC_NS, CLK_PERIOD_NS),
                                          ns2cyc(T_ACC_NS, CLK_PERIOD_NS),
                                          ns2cyc(T_OE_NS, CLK_PERIOD_NS));
  localparam int unsigned WE_CYC   = max3(ns2cyc(T_WP_NS, CLK_PERIOD_NS),
                                          ns2cyc(T_AW_NS, CLK_PERIOD_NS),
                                          ns2cyc(T_DW_NS, CLK_PERIOD_NS));
  localparam int unsigned WC_CYC   = ns2cyc(T_WC_NS, CLK_PERIOD_NS);
  localparam int unsigned TAIL_CYC = (WC_CYC > WE_CYC) ? (WC_CYC - WE_CYC) : 1;
  localparam int unsigned HZ_CYC   = ns2cyc(T_HZ_NS, CLK_PERIOD_NS);
  localparam int unsigned REC_CYC  = ns2cyc(T_REC_NS, CLK_PERIOD_NS);
  localparam int unsigned SEQ_MAX  = max3(RD_CYC, WE_CYC, TAIL_CYC);
  localparam int unsigned SEQ_W    = $clog2(SEQ_MAX + 1);
  localparam int unsigned HZ_W     = $clog2(HZ_CYC + 1);

  localparam logic [SEQ_W-1:0] RD_LD   = SEQ_W'(RD_CYC - 1);
  localparam logic [SEQ_W-1:0] WE_LD   = SEQ_W'(WE_CYC - 1);
  localparam logic [SEQ_W-1:0] TAIL_LD = SEQ_W'(TAIL_CYC - 1);
  localparam logic [HZ_W-1:0]  HZ_LD   = HZ_W'(HZ_CYC - 1);

  ctrl_state_e       state_q;
  logic              cs1_n_q, cs2_q, oe_n_q, we_n_q, dq_oe_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dq_q;

  logic             accept, stby_block, rec_busy, sleep_exit;
  logic             seq_load, seq_zero, hz_zero, rd_done;
  logic [SEQ_W-1:0] seq_val;

  assign stby_block = RETAIN_EN && standby_req;
  assign req_ready  = (state_q == ST_IDLE) && !stby_block && !rec_busy
                      && !(req_write && !hz_zero);
  assign accept     = req_valid && req_ready;
  assign rd_done    = (state_q == ST_RD) && seq_zero;
  assign sleep_exit = (state_q == ST_SLEEP) && !standby_req;

  always_comb begin
    seq_load = 1'b0;
    seq_val  = '0;
    if (accept) begin
      seq_load = 1'b1;
      seq_val  = req_write ? WE_LD : RD_LD;
    end else if ((state_q == ST_WR) && seq_zero) begin
      seq_load = 1'b1;
      seq_val  = TAIL_LD;
    end
  end

  sram_down_cnt #(.W(SEQ_W)) u_seq_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (seq_load),
    .load_val (seq_val),
    .zero     (seq_zero)
  );

  sram_down_cnt #(.W(HZ_W)) u_hz_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rd_done),
    .load_val (HZ_LD),
    .zero     (hz_zero)
  );

  sram_retention_gate #(.EN(RETAIN_EN), .REC_CYC(REC_CYC)) u_rec_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sleep_exit),
    .busy  (rec_busy)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_rd_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (rd_done),
    .dq_in    (mem_dq_in),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs1_n_q <= 1'b1;
      cs2_q   <= 1'b0;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      addr_q  <= '0;
      dq_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            cs1_n_q <= 1'b0;
            cs2_q   <= 1'b1;
            addr_q  <= req_addr;
            if (req_write) begin
              we_n_q  <= 1'b0;
              dq_oe_q <= 1'b1;
              dq_q    <= req_wdata;
              state_q <= ST_WR;
            end else begin
              oe_n_q  <= 1'b0;
              state_q <= ST_RD;
            end
          end else if (stby_block) begin
            state_q <= ST_SLEEP;
          end
        end
        ST_RD: begin
          if (seq_zero) begin
            oe_n_q  <= 1'b1;
            cs1_n_q <= 1'b1;
            cs2_q   <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        ST_WR: begin
          if (seq_zero) begin
            we_n_q  <= 1'b1;
            state_q <= ST_WTAIL;
          end
        end
        ST_WTAIL: begin
          if (seq_zero) begin
            cs1_n_q <= 1'b1;
            cs2_q   <= 1'b0;
            dq_oe_q <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        ST_SLEEP: begin
          if (!standby_req) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_cs1_n  = cs1_n_q;
  assign mem_cs2    = cs2_q;
  assign mem_oe_n   = oe_n_q;
  assign mem_we_n   = we_n_q;
  assign mem_addr   = addr_q;
  assign mem_dq_out = dq_q;
  assign mem_dq_oe  = dq_oe_q;
endmodule

// File: rtl/sram_host_ctrl_chk.sv
`timescale 1ns/1ps
module sram_host_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned T_WP_NS       = 55,
  parameter int unsigned T_AW_NS       = 60,
  parameter int unsigned T_DW_NS       = 30,
  parameter int unsigned T_HZ_NS       = 30
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rd_valid,
  input logic mem_cs1_n,
  input logic mem_cs2,
  input logic mem_oe_n,
  input logic mem_we_n,
  input logic mem_dq_oe
);
  localparam int unsigned WE_CYC = max3(ns2cyc(T_WP_NS, CLK_PERIOD_NS),
                                        ns2cyc(T_AW_NS, CLK_PERIOD_NS),
                                        ns2cyc(T_DW_NS, CLK_PERIOD_NS));
  localparam int unsigned HZ_CYC = ns2cyc(T_HZ_NS, CLK_PERIOD_NS);

  logic [15:0] we_low_q;
  logic [15:0] since_oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_q   <= '0;
      since_oe_q <= '1;
    end else begin
      if (!mem_we_n) begin
        if (we_low_q != '1) we_low_q <= we_low_q + 1'b1;
      end else begin
        we_low_q <= '0;
      end
      if (!mem_oe_n)             since_oe_q <= '0;
      else if (since_oe_q != '1) since_oe_q <= since_oe_q + 1'b1;
    end
  end

  // R2
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n);

  // R4
  drive_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R4
  we_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (32'(we_low_q) >= WE_CYC));

  // R6
  turnaround_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (32'(since_oe_q) >= HZ_CYC));

  // R3
  rd_valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R7
  accept_selects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!mem_cs1_n && mem_cs2));

  // R7
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs1_n |-> !req_ready);

  // R8
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs1_n || !mem_cs2) |-> (mem_oe_n && mem_we_n && !mem_dq_oe));
endmodule

bind sram_host_ctrl sram_host_ctrl_chk #(
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .T_WP_NS       (T_WP_NS),
  .T_AW_NS       (T_AW_NS),
  .T_DW_NS       (T_DW_NS),
  .T_HZ_NS       (T_HZ_NS)
) u_chk (.*);

// File: tb/sram_host_ctrl_tb.sv
`timescale 1ns/1ps
module sram_host_ctrl_tb;
  function automatic int unsigned cdiv(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction
  function automatic int unsigned mx(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  localparam int unsigned CLK_NS = 20;
  localparam int unsigned T_REC  = 1000;
  localparam int RD_E   = int'(mx(mx(cdiv(70, CLK_NS), cdiv(70, CLK_NS)), cdiv(40, CLK_NS)));
  localparam int WE_E   = int'(mx(mx(cdiv(55, CLK_NS), cdiv(60, CLK_NS)), cdiv(30, CLK_NS)));
  localparam int WC_E   = int'(cdiv(70, CLK_NS));
  localparam int TAIL_E = (WC_E > WE_E) ? (WC_E - WE_E) : 1;
  localparam int HZ_E   = int'(cdiv(30, CLK_NS));
  localparam int REC_E  = int'(cdiv(T_REC, CLK_NS));

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, standby_req = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid;
  logic [7:0]  rd_data;
  logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [16:0] mem_addr;
  logic [7:0]  mem_dq_out, mem_dq_in;

  sram_host_ctrl #(.CLK_PERIOD_NS(CLK_NS), .T_REC_NS(T_REC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .standby_req(standby_req),
    .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Memory model: data is trustworthy only once the output enable has been low long enough.
  logic [7:0] model_mem [int];
  logic [7:0] mem_rd = 8'h00;
  int oe_seen = 0;
  always @(posedge clk) oe_seen <= (!mem_cs1_n && mem_cs2 && !mem_oe_n) ? oe_seen + 1 : 0;
  always @(negedge clk)
    mem_rd = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h00;
  assign mem_dq_in = (oe_seen >= RD_E - 1) ? mem_rd : ~mem_rd;
  always @(posedge mem_we_n)
    if (!mem_cs1_n && mem_cs2 && mem_dq_oe) model_mem[int'(mem_addr)] = mem_dq_out;

  // Pin monitor, sampled on the falling edge.
  int cs_run = 0, we_run = 0, oe_low = 0, oe_rise = -1000, last_gap = -1, rv_cnt = 0;
  bit wr_seen = 0, prev_dq_oe = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_cs1_n && mem_cs2) begin
        cs_run++;
        if (mem_dq_oe) wr_seen = 1;
        check(!req_ready, "R7 ready low while selected", int'(req_ready), 0);
        check(mem_oe_n || mem_we_n, "R2 oe and we both low", 0, 1);
        if (mem_dq_oe) check(mem_oe_n, "R4 oe high while driving", int'(mem_oe_n), 1);
      end else if (cs_run > 0) begin
        if (wr_seen) check(cs_run == WE_E + TAIL_E, "R5 write select length", cs_run, WE_E + TAIL_E);
        else         check(cs_run == RD_E, "R2 read select length", cs_run, RD_E);
        cs_run = 0;
        wr_seen = 0;
      end
      if (!mem_we_n) we_run++;
      else if (we_run > 0) begin
        check(we_run == WE_E, "R4 write strobe width", we_run, WE_E);
        we_run = 0;
      end
      if (!mem_oe_n) oe_low++;
      else if (oe_low > 0) begin
        check(oe_low == RD_E, "R2 output enable width", oe_low, RD_E);
        oe_low = 0;
        oe_rise = cyc;
      end
      if (mem_dq_oe && !prev_dq_oe) begin
        last_gap = cyc - oe_rise;
        check(last_gap >= HZ_E, "R6 turnaround gap", last_gap, HZ_E);
      end
      prev_dq_oe = mem_dq_oe;
      if (rd_valid) rv_cnt++;
    end
  end

  int n_reads = 0;

  task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d, output int acc);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) @(negedge clk);
    acc = cyc + 1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    int acc;
    issue(1'b1, a, d, acc);
    while (!mem_cs1_n) @(negedge clk);
  endtask

  task automatic do_read(input logic [16:0] a, input logic [7:0] exp);
    int acc;
    issue(1'b0, a, 8'h00, acc);
    n_reads++;
    while (!rd_valid) @(negedge clk);
    check(cyc == acc + RD_E, "R3 read data latency", cyc - acc, RD_E);
    check(rd_data == exp, "R3 read data value", int'(rd_data), int'(exp));
  endtask

  function automatic logic [16:0] addr_of(input int i);
    if (i == 0) return 17'h00000;
    if (i == 1) return 17'h1FFFF;
    if (i < 19) return 17'(1) << (i - 2);
    return ~(17'(1) << (i - 19));
  endfunction

  function automatic logic [7:0] dpat(input logic [16:0] a);
    return a[7:0] ^ a[16:9] ^ 8'h3C;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements): actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(mem_cs1_n && !mem_cs2, "R1 deselected after reset", int'({mem_cs1_n, mem_cs2}), 2);
    check(mem_oe_n && mem_we_n, "R1 strobes high after reset", int'({mem_oe_n, mem_we_n}), 3);
    check(!mem_dq_oe && !rd_valid, "R1 no drive and no data", int'({mem_dq_oe, rd_valid}), 0);
    check(req_ready, "R1 ready after reset", int'(req_ready), 1);

    // R2 R3 R4 R5 address sweep
    for (int i = 0; i < 36; i++) do_write(addr_of(i), dpat(addr_of(i)));
    for (int i = 0; i < 36; i++) do_read(addr_of(i), dpat(addr_of(i)));

    // R5 data pattern sweep, write then immediate read-back
    for (int b = 0; b < 10; b++) begin
      logic [7:0] d;
      d = (b < 8) ? (8'h01 << b) : ((b == 8) ? 8'h00 : 8'hFF);
      do_write(17'h0A5A5, d);
      do_read(17'h0A5A5, d);
    end

    // R6 read after read goes at once; R11 write after read waits
    do_read(17'h00010, dpat(17'h00010));
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h00020;
    #1;
    check(req_ready, "R6 read accepted right after read", int'(req_ready), 1);
    do_read(17'h00020, dpat(17'h00020));
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00040; req_wdata = 8'hC3;
    #1;
    check(!req_ready, "R11 write held in turnaround", int'(req_ready), 0);
    do_write(17'h00040, 8'hC3);
    check(last_gap == HZ_E, "R6 write waits exactly the float time", last_gap, HZ_E);
    do_read(17'h00040, 8'hC3);

    // R8 standby from idle with a pending read
    standby_req = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h00004;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check(!req_ready && mem_cs1_n && !mem_cs2, "R8 retention holds off request",
            int'({req_ready, mem_cs1_n, mem_cs2}), 2);
    end
    // R9 recovery lockout length
    standby_req = 1'b0;
    c0 = cyc;
    #1;
    while (!req_ready) @(negedge clk);
    check(cyc - c0 == REC_E + 1, "R9 recovery lockout cycles", cyc - c0 - 1, REC_E);
    do_read(17'h00004, dpat(17'h00004));

    // R10 standby raised in the middle of a write
    begin
      int acc;
      issue(1'b1, 17'h1234A, 8'h96, acc);
      standby_req = 1'b1;
      while (!mem_cs1_n) @(negedge clk);
      check(cyc == acc + WE_E + TAIL_E, "R10 write finished before retention", cyc - acc, WE_E + TAIL_E);
      repeat (3) @(negedge clk);
      check(mem_cs1_n && !mem_cs2 && !req_ready, "R10 retention after write",
            int'({mem_cs1_n, mem_cs2, req_ready}), 4);
      standby_req = 1'b0;
      repeat (REC_E + 2) @(negedge clk);
      do_read(17'h1234A, 8'h96);
    end

    repeat (3) @(negedge clk);
    check(rv_cnt == n_reads, "R3 one strobe per read", rv_cnt, n_reads);
    finish_run();
  end
endmodule